// File: doc/BRIEF.md
# Universal Shift Register on a Shared Bidirectional Bus

This block is an 8-bit register with four operating modes: it can keep its value, move its contents one place toward the high end, move them one place toward the low end, or take a new word in parallel. The parallel word enters and leaves through one shared bidirectional port. For synthesis and test, that port is split into three signals. The pad value comes in on `ioIn`. The register value goes out on `ioOut`. A single enable, `ioOe`, decides whether the pad is driven. The pad buffer itself is outside this block.

Two always-live serial taps come straight from the end flip-flops, bit 0 and bit 7. Several copies of the block can be chained through these taps and the serial inputs to make longer shift words. A low level on the reset input clears the register at once, with no clock needed. Every other state change happens on the rising clock edge.

Top module: `usr_shift_bus`

## Requirements
- R1: While `rstN` is low, the register reads all zeros immediately, whatever the clock or the select inputs do.
- R2: With `sel` = 2'b00 (hold), the register keeps its value across a rising edge.
- R3: With `sel` = 2'b01 (shift up), bit i takes the old bit i-1 on the rising edge, and bit 0 takes `serRight`.
- R4: With `sel` = 2'b10 (shift down), bit i takes the old bit i+1 on the rising edge, and bit 7 takes `serLeft`.
- R5: With `sel` = 2'b11 (load), the register captures `ioIn` on the rising edge.
- R6: `ioOe` is 1 exactly when both bits of `oeN` are 0 and `sel` is not 2'b11. `ioOut` always shows the register value.
- R7: The register updates the same way whether the port is driven or released.
- R8: `tapLow` equals register bit 0 and `tapHigh` equals bit 7 at all times, including while `ioOe` is 0.
- R9: Reset does not affect the enable logic. During reset, `ioOe` still follows R6, so an enabled port drives zeros.
- R10: Two blocks form one 16-bit shifter when connected as follows. The low block's `tapHigh` feeds the high block's `serRight`. The high block's `tapLow` feeds the low block's `serLeft`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low clear |
| sel | input | 2 | Mode select: 00 hold, 01 shift up, 10 shift down, 11 load |
| oeN | input | 2 | Active-low port enables; both must be low to drive |
| serRight | input | 1 | Serial bit entering bit 0 on shift up |
| serLeft | input | 1 | Serial bit entering bit 7 on shift down |
| ioIn | input | 8 | Value seen at the shared pads |
| ioOut | output | 8 | Register value offered to the pads |
| ioOe | output | 1 | Pad drive enable |
| tapLow | output | 1 | Register bit 0 |
| tapHigh | output | 1 | Register bit 7 |

## Verification
`ioOut` carries the register value whether or not the pad is enabled. A wrong bit inside the block therefore shows up at the ports one clock edge after the update that caused it, with no need to drive the bus. The end bits also appear on the taps, and in the cascaded pair they pass into the neighbouring block on the next shift. So a fault at a block boundary corrupts the 16-bit word one edge later. A wrong enable decode shows up at once on `ioOe`, because that signal is purely combinational from `sel` and `oeN`.

// File: rtl/usr_pkg.sv
package usr_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_LOAD = 2'b11
  } mode_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic shiftUp;
    logic shiftDown;
    logic load;
    logic drive;
  } ctrl_s;

endpackage

// File: rtl/usr_ctrl.sv
module usr_ctrl
  import usr_pkg::*;
#(
  parameter int OE_INPUTS = 2
) (
  input  logic [1:0]           sel,
  input  logic [OE_INPUTS-1:0] oeN,
  output ctrl_s                ctrl
);

  mode_e mode;
  logic  allEnabled;

  always_comb begin
    mode = mode_e'(sel);
  end

  // All enable inputs must be low for the port to drive
  always_comb begin
    allEnabled = ~|oeN;
  end

  always_comb begin
    ctrl = '0;
    unique case (mode)
      MODE_UP:   ctrl.shiftUp   = 1'b1;
      MODE_DOWN: ctrl.shiftDown = 1'b1;
      MODE_LOAD: ctrl.load      = 1'b1;
      default:   ;
    endcase
    // Load mode releases the port so it can receive data
    ctrl.drive = allEnabled && (mode != MODE_LOAD);
  end

endmodule

// File: rtl/usr_datapath.sv
module usr_datapath
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_s            ctrl,
  input  logic             serRight,
  input  logic             serLeft,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] q
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] fromBelow;
  logic [WIDTH-1:0] fromAbove;
  logic [WIDTH-1:0] nextQ;

  // Neighbour source of each bit; the end bits take the serial inputs
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_low
      assign fromBelow[i] = serRight;
    end else begin : g_lowMid
      assign fromBelow[i] = q[i-1];
    end
    if (i == MSB) begin : g_high
      assign fromAbove[i] = serLeft;
    end else begin : g_highMid
      assign fromAbove[i] = q[i+1];
    end

    always_comb begin
      if (ctrl.load)           nextQ[i] = parIn[i];
      else if (ctrl.shiftUp)   nextQ[i] = fromBelow[i];
      else if (ctrl.shiftDown) nextQ[i] = fromAbove[i];
      else                     nextQ[i] = q[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= '0;
    else       q <= nextQ;
  end

  always_comb begin
    AST_ONE_STROBE: assert ($onehot0({ctrl.shiftUp, ctrl.shiftDown, ctrl.load})); // R2
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) !rstN |-> (q == '0)); // R1

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.shiftUp || ctrl.shiftDown || ctrl.load) |=> $stable(q)); // R2

  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.shiftUp |=> (q == {$past(q[MSB-1:0]), $past(serRight)})); // R3

  AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.shiftDown |=> (q == {$past(serLeft), $past(q[MSB:1])})); // R4

  AST_LOAD_CAPT: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> (q == $past(parIn))); // R5

endmodule

// File: rtl/usr_shift_bus.sv
module usr_shift_bus
  import usr_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int OE_INPUTS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           sel,
  input  logic [OE_INPUTS-1:0] oeN,
  input  logic                 serRight,
  input  logic                 serLeft,
  input  logic [WIDTH-1:0]     ioIn,
  output logic [WIDTH-1:0]     ioOut,
  output logic                 ioOe,
  output logic                 tapLow,
  output logic                 tapHigh
);

  localparam int MSB = WIDTH - 1;

  ctrl_s            ctrl;
  logic [WIDTH-1:0] regQ;

  usr_ctrl #(.OE_INPUTS(OE_INPUTS)) u_ctrl (
    .sel  (sel),
    .oeN  (oeN),
    .ctrl (ctrl)
  );

  usr_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .serRight (serRight),
    .serLeft  (serLeft),
    .parIn    (ioIn),
    .q        (regQ)
  );

  assign ioOut   = regQ;
  assign ioOe    = ctrl.drive;
  assign tapLow  = regQ[0];
  assign tapHigh = regQ[MSB];

  AST_LOAD_HIZ: assert property (@(posedge clk) (sel == 2'b11) |-> !ioOe); // R6

  AST_TAP_LIVE: assert property (@(posedge clk)
    (tapLow == ioOut[0]) && (tapHigh == ioOut[MSB])); // R8

  AST_RESET_DRIVE: assert property (@(posedge clk)
    (!rstN && ioOe) |-> (ioOut == '0)); // R9

endmodule

// File: tb/sim_usr_shift_bus.sv
module sim_usr_shift_bus;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] sel = 2'b00;
  logic [1:0] oeN = 2'b11;
  logic       serR = 1'b0;
  logic       serL = 1'b0;
  logic [7:0] ext0 = 8'h00;
  logic [7:0] ext1 = 8'h00;

  logic [7:0] out0, out1, in0, in1;
  logic       oe0, oe1, tl0, th0, tl1, th1;

  int total = 0;
  int bad = 0;
  logic [15:0] model = 16'h0;

  always #5 clk = ~clk;

  // Pad resolution: a driven port sees its own value
  assign in0 = oe0 ? out0 : ext0;
  assign in1 = oe1 ? out1 : ext1;

  // Low half of the cascade
  usr_shift_bus u0 (
    .clk(clk), .rstN(rstN), .sel(sel), .oeN(oeN),
    .serRight(serR), .serLeft(tl1), .ioIn(in0),
    .ioOut(out0), .ioOe(oe0), .tapLow(tl0), .tapHigh(th0));

  // High half of the cascade
  usr_shift_bus u1 (
    .clk(clk), .rstN(rstN), .sel(sel), .oeN(oeN),
    .serRight(th0), .serLeft(serL), .ioIn(in1),
    .ioOut(out1), .ioOe(oe1), .tapLow(tl1), .tapHigh(th1));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic expOe();
    return (oeN == 2'b00) && (sel != 2'b11);
  endfunction

  task automatic checkAll(input string tag);
    chk({tag, " R10 word"}, {out1, out0}, model);
    chk({tag, " R8 taps"}, {12'h0, th1, tl1, th0, tl0},
        {12'h0, model[15], model[8], model[7], model[0]});
    chk({tag, " R6 oe"}, {14'h0, oe1, oe0}, {14'h0, expOe(), expOe()});
  endtask

  // One clock: the model follows the inputs present at the edge
  task automatic step(input string tag);
    @(posedge clk);
    if (rstN) begin
      case (sel)
        2'b01: model = {model[14:0], serR};
        2'b10: model = {serL, model[15:1]};
        2'b11: model = {ext1, ext0};
        default: ;
      endcase
    end else model = 16'h0;
    #1;
    checkAll(tag);
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2;
    checkAll("R1 reset at start");
    #20;
    rstN = 1'b1;
    @(negedge clk);

    // R5 parallel load with the port released
    sel = 2'b11; oeN = 2'b00; ext0 = 8'hA5; ext1 = 8'h3C;
    step("R5 load");
    chk("R6 load releases port", {15'h0, oe0}, 16'h0);

    // R2 hold, port enabled then released (R7)
    sel = 2'b00; ext0 = 8'hFF; ext1 = 8'hFF;
    step("R2 hold driven");
    oeN = 2'b01;
    step("R2 R7 hold released");
    oeN = 2'b10;
    step("R2 R7 hold other enable");

    // R3 shift up across the block boundary (R10)
    sel = 2'b01; oeN = 2'b00;
    for (int i = 0; i < 10; i++) begin
      serR = i[0] ^ i[2];
      step("R3 R10 shift up");
    end
    oeN = 2'b11;
    for (int i = 0; i < 4; i++) begin
      serR = 1'b1;
      step("R3 R7 R8 shift up released");
    end

    // R4 shift down across the boundary
    sel = 2'b10;
    for (int i = 0; i < 12; i++) begin
      serL = i[1];
      step("R4 R10 shift down");
    end
    oeN = 2'b00;
    for (int i = 0; i < 4; i++) begin
      serL = 1'b0;
      step("R4 R7 shift down driven");
    end

    // Reload and a mixed pattern
    sel = 2'b11; ext0 = 8'h81; ext1 = 8'h7E;
    step("R5 second load");
    for (int i = 0; i < 20; i++) begin
      sel = i[1:0]; serR = i[0]; serL = ~i[2];
      ext0 = 8'(i * 37); ext1 = 8'(i * 91);
      oeN = i[3:2];
      step("R2 R3 R4 R5 mixed");
    end

    // R1 asynchronous reset in the middle of a cycle
    sel = 2'b11; ext0 = 8'hF0; ext1 = 8'h0F;
    step("R5 preload");
    sel = 2'b00; oeN = 2'b00;
    #2;
    rstN = 1'b0;
    #1;
    model = 16'h0;
    checkAll("R1 async reset");
    chk("R9 oe during reset", {15'h0, oe0}, 16'h1);
    // R1 reset overrides clock and load select
    sel = 2'b11;
    step("R1 reset over load");
    sel = 2'b00;
    oeN = 2'b01;
    #1;
    chk("R9 oe follows enables in reset", {15'h0, oe0}, 16'h0);
    @(negedge clk);
    rstN = 1'b1;
    sel = 2'b01; serR = 1'b1;
    step("R3 after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule